// File: doc/BRIEF.md
# Dual-Clock Presettable Up/Down Counter

This block is a four-bit counter that advances on one of two separate count strobes: one strobe steps it up, the other steps it down. A strobe's rising edge counts only while the opposite strobe sits high. An elaboration parameter chooses a decade modulus (0 to 9) or a binary modulus (0 to 15). A master clear and an active-low parallel load both act on the count output at once, with no wait for any clock. Two active-low flags report the terminal count: a carry at the top of the range and a borrow at zero. A second counter can take these flags directly as its own strobes. No glue logic is needed, and the next stage moves exactly when this one wraps.

Everything runs from one free-running system clock. Both strobes pass through two-flop synchronizers, and the block detects their rising edges after synchronization. The flags come combinationally from the effective count and the synchronized strobe levels.

Top module: `bidir_jam_counter`

## Requirements
- R1: A rising edge on `inc_clk` adds one to `count` when `dec_clk` is high at that edge. When `dec_clk` is low, the edge has no effect.
- R2: A rising edge on `dec_clk` subtracts one from `count` when `inc_clk` is high at that edge. When `inc_clk` is low, the edge has no effect.
- R3: The count holds in these cases: both strobes are steady, both strobes rise together, or a strobe edge is ignored under R1 or R2.
- R4: While `clear` is 1, `count` reads 0 at once, with no clock edge needed. This beats load and counting. After `clear` is released, the count stays 0 until the next event.
- R5: While `load_n` is 0 and `clear` is 0, `count` equals `jam` at once and strobe edges do not count. After `load_n` is released, the count keeps the loaded value.
- R6: In decade mode, counting up goes from 9 to 0 and counting down goes from 0 to 9.
- R7: In binary mode, counting up goes from 15 to 0 and counting down goes from 0 to 15.
- R8: `carry_n` is 0 only while `inc_clk` (synchronized) is low and `count` is at the top value: 9 in decade mode, 15 in binary mode. It returns to 1 when `inc_clk` rises.
- R9: `borrow_n` is 0 only while `dec_clk` (synchronized) is low and `count` is 0. It returns to 1 when `dec_clk` rises.
- R10: Feed `carry_n` of one stage into the next stage's `inc_clk`, and `borrow_n` into its `dec_clk`. The next stage then steps up once on this stage's upward wrap and down once on its downward wrap.
- R11: In decade mode, a loaded value from 10 to 15 is kept. Counting up from it goes to the next binary value, and 15 goes to 0. Counting down subtracts one. `carry_n` stays 1 at these values.
- R12: While `rst_n` is 0, `count` is 0. Both flags are 1 when both strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low system reset, released synchronously inside |
| clear | input | 1 | Active-high master clear, takes effect at once |
| load_n | input | 1 | Active-low parallel load of `jam`, takes effect at once |
| jam | input | 4 | Parallel load value |
| inc_clk | input | 1 | Count-up strobe, asynchronous to `clk` |
| dec_clk | input | 1 | Count-down strobe, asynchronous to `clk` |
| count | output | 4 | Current count |
| carry_n | output | 1 | Active-low terminal-count flag for counting up |
| borrow_n | output | 1 | Active-low terminal-count flag for counting down |

## Verification
The bench targets the following corner cases, and each one exposes a specific fault:
- **Wrap points in both moduli.** A wrong modulus would run 9 to 10 or 15 to 9.
- **The gating between the two strobes.** A missing gate would count while the opposite strobe is held low, or would count on two edges that arrive together.
- **The timing of the flags inside the low phase.** A flag tied to the raw count would pulse at the wrong time or stick low. In the cascaded pair this shows up as a second stage that never moves or moves twice.
- **Load and clear with strobe activity present.** A priority fault would let counts leak through, or would lose the loaded value once the load is released.
- **Out-of-range decade loads.** Treating these as the top value would give a spurious carry.

// File: rtl/bjc_pkg.sv
package bjc_pkg;

  // One system-clock decision about the count
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

endpackage

// File: rtl/bjc_edge_sync.sv
module bjc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise
);

  logic [STAGES-1:0] stage_q;
  logic              prev_q;

  // First stage samples the raw strobe; idle level is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= 1'b1;
    else        stage_q[0] <= async_in;
  end

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= 1'b1;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= stage_q[STAGES-1];
  end

  assign level = stage_q[STAGES-1];
  assign rise  = stage_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/bjc_step_arbiter.sv
module bjc_step_arbiter
  import bjc_pkg::*;
(
  input  logic  up_lvl,
  input  logic  up_rise,
  input  logic  dn_lvl,
  input  logic  dn_rise,
  output step_e step
);

  logic up_ok;
  logic dn_ok;

  // Each edge counts only while the opposite strobe is high and not rising too
  assign up_ok = up_rise & dn_lvl & ~dn_rise;
  assign dn_ok = dn_rise & up_lvl & ~up_rise;

  always_comb begin
    step = STEP_HOLD;
    if (up_ok)      step = STEP_UP;
    else if (dn_ok) step = STEP_DOWN;
  end

endmodule

// File: rtl/bjc_next_count.sv
module bjc_next_count
  import bjc_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter bit DECADE = 1'b1
) (
  input  logic [CNT_W-1:0] cur,
  input  step_e            step,
  output logic [CNT_W-1:0] nxt
);

  localparam logic [CNT_W-1:0] TOP = DECADE ? CNT_W'(9) : {CNT_W{1'b1}};

  logic [CNT_W-1:0] up_val;
  logic [CNT_W-1:0] dn_val;

  generate
    if (DECADE) begin : g_decade
      // Values above nine keep stepping in binary until the natural wrap
      assign up_val = (cur == TOP || cur == {CNT_W{1'b1}}) ? '0 : cur + 1'b1;
      assign dn_val = (cur == '0) ? TOP : cur - 1'b1;
    end else begin : g_binary
      assign up_val = cur + 1'b1;
      assign dn_val = cur - 1'b1;
    end
  endgenerate

  always_comb begin
    unique case (step)
      STEP_UP:   nxt = up_val;
      STEP_DOWN: nxt = dn_val;
      default:   nxt = cur;
    endcase
  end

endmodule

// File: rtl/bjc_flags.sv
module bjc_flags #(
  parameter int CNT_W  = 4,
  parameter bit DECADE = 1'b1
) (
  input  logic [CNT_W-1:0] count,
  input  logic             up_lvl,
  input  logic             dn_lvl,
  output logic             carry_n,
  output logic             borrow_n
);

  localparam logic [CNT_W-1:0] TOP = DECADE ? CNT_W'(9) : {CNT_W{1'b1}};

  assign carry_n  = ~((count == TOP) & ~up_lvl);
  assign borrow_n = ~((count == '0)  & ~dn_lvl);

endmodule

// File: rtl/bidir_jam_counter.sv
module bidir_jam_counter
  import bjc_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter bit DECADE      = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load_n,
  input  logic [CNT_W-1:0] jam,
  input  logic             inc_clk,
  input  logic             dec_clk,
  output logic [CNT_W-1:0] count,
  output logic             carry_n,
  output logic             borrow_n
);

  logic [1:0]       rst_pipe_q;
  logic             rst_n_int;
  logic             up_lvl, up_rise, dn_lvl, dn_rise;
  step_e            step;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_step;
  logic             cnt_en;

  // Reset: asserted at once, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  bjc_edge_sync #(.STAGES(SYNC_STAGES)) u_up_sync (
    .clk(clk), .rst_n(rst_n_int), .async_in(inc_clk),
    .level(up_lvl), .rise(up_rise)
  );

  bjc_edge_sync #(.STAGES(SYNC_STAGES)) u_dn_sync (
    .clk(clk), .rst_n(rst_n_int), .async_in(dec_clk),
    .level(dn_lvl), .rise(dn_rise)
  );

  bjc_step_arbiter u_arb (
    .up_lvl(up_lvl), .up_rise(up_rise),
    .dn_lvl(dn_lvl), .dn_rise(dn_rise),
    .step(step)
  );

  bjc_next_count #(.CNT_W(CNT_W), .DECADE(DECADE)) u_next (
    .cur(cnt_q), .step(step), .nxt(cnt_step)
  );

  // Next state: clear over load over counting
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clear) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (!load_n) begin
      cnt_d  = jam;
      cnt_en = 1'b1;
    end else if (step != STEP_HOLD) begin
      cnt_d  = cnt_step;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)  cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // Clear and load reach the output without waiting for a clock edge
  always_comb begin
    if (clear)        count = '0;
    else if (!load_n) count = jam;
    else              count = cnt_q;
  end

  bjc_flags #(.CNT_W(CNT_W), .DECADE(DECADE)) u_flags (
    .count(count), .up_lvl(up_lvl), .dn_lvl(dn_lvl),
    .carry_n(carry_n), .borrow_n(borrow_n)
  );

endmodule

// File: rtl/bjc_checker.sv
module bjc_checker #(
  parameter int CNT_W  = 4,
  parameter bit DECADE = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear,
  input logic             load_n,
  input logic [CNT_W-1:0] jam,
  input logic [CNT_W-1:0] count,
  input logic             carry_n,
  input logic             borrow_n
);

  localparam logic [CNT_W-1:0] TOP = DECADE ? CNT_W'(9) : {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] f_inc(input logic [CNT_W-1:0] v);
    if (DECADE && (v == TOP || v == {CNT_W{1'b1}})) return '0;
    return v + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] f_dec(input logic [CNT_W-1:0] v);
    if (DECADE && v == '0) return TOP;
    return v - 1'b1;
  endfunction

  // R6 R7: without clear or load, the count only moves one step in the modulus
  assert_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !clear && $past(load_n && !clear) && count != $past(count))
      |-> (count == f_inc($past(count)) || count == f_dec($past(count))));

  // R4: the cleared value persists into the next cycle
  assert_clear_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (clear || !load_n || count == '0));

  // R5: a released load keeps the loaded value, at most one step away
  assert_load_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && !clear) |=> (clear || !load_n || count == $past(jam) ||
                             count == f_inc($past(jam)) || count == f_dec($past(jam))));

  // R8: carry only at the top value
  assert_carry_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_n |-> count == TOP);

  // R9: borrow only at zero
  assert_borrow_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !borrow_n |-> count == '0);

endmodule

bind bidir_jam_counter bjc_checker #(.CNT_W(CNT_W), .DECADE(DECADE)) u_bjc_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .load_n(load_n), .jam(jam),
  .count(count), .carry_n(carry_n), .borrow_n(borrow_n)
);

// File: tb/bidir_jam_counter_test.sv
`timescale 1ns/1ps
module bidir_jam_counter_test;

  localparam int P = 6;  // system cycles per strobe phase

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clear = 1'b0;
  logic       load_n = 1'b1;
  logic [3:0] jam = 4'd0;
  logic       inc_clk = 1'b1;
  logic       dec_clk = 1'b1;

  logic [3:0] cnt_d, cnt_h, cnt_b;
  logic       cy_d, bw_d, cy_h, bw_h, cy_b, bw_b;

  always #2 clk = ~clk;

  // Decade stage under test
  bidir_jam_counter #(.DECADE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .load_n(load_n), .jam(jam),
    .inc_clk(inc_clk), .dec_clk(dec_clk),
    .count(cnt_d), .carry_n(cy_d), .borrow_n(bw_d)
  );

  // Second decade stage driven by the first stage's flags
  bidir_jam_counter #(.DECADE(1'b1)) uut_hi (
    .clk(clk), .rst_n(rst_n), .clear(clear), .load_n(load_n), .jam(jam),
    .inc_clk(cy_d), .dec_clk(bw_d),
    .count(cnt_h), .carry_n(cy_h), .borrow_n(bw_h)
  );

  // Binary stage sharing the same strobes
  bidir_jam_counter #(.DECADE(1'b0)) uut_bin (
    .clk(clk), .rst_n(rst_n), .clear(clear), .load_n(load_n), .jam(jam),
    .inc_clk(inc_clk), .dec_clk(dec_clk),
    .count(cnt_b), .carry_n(cy_b), .borrow_n(bw_b)
  );

  typedef struct {
    int         unit;
    string      req;
    logic [3:0] cnt;
    logic       cy;
    logic       bw;
  } exp_t;

  exp_t exp_q[$];
  event chk_ev;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  // Monitor: pops expected items and compares against the live outputs
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        logic [3:0] ac;
        logic acy, abw;
        e = exp_q.pop_front();
        case (e.unit)
          0:       begin ac = cnt_d; acy = cy_d; abw = bw_d; end
          1:       begin ac = cnt_h; acy = cy_h; abw = bw_h; end
          default: begin ac = cnt_b; acy = cy_b; abw = bw_b; end
        endcase
        n_chk++;
        if (ac !== e.cnt || acy !== e.cy || abw !== e.bw) begin
          n_fail++;
          $display("FAIL %s unit%0d: got count=%0d carry_n=%b borrow_n=%b, expected count=%0d carry_n=%b borrow_n=%b",
                   e.req, e.unit, ac, acy, abw, e.cnt, e.cy, e.bw);
        end
      end
    end
  end

  task automatic expect_u(input int u, input string r, input int c, input bit cy, input bit bw);
    exp_t e;
    e.unit = u; e.req = r; e.cnt = 4'(c); e.cy = cy; e.bw = bw;
    exp_q.push_back(e);
  endtask

  task automatic go();
    -> chk_ev;
    #1;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic up_lo();  inc_clk = 1'b0; cyc(P); endtask
  task automatic up_hi();  inc_clk = 1'b1; cyc(P); endtask
  task automatic dn_lo();  dec_clk = 1'b0; cyc(P); endtask
  task automatic dn_hi();  dec_clk = 1'b1; cyc(P); endtask
  task automatic up_pulse(); up_lo(); up_hi(); endtask
  task automatic dn_pulse(); dn_lo(); dn_hi(); endtask

  task automatic preset(input int v);
    @(negedge clk);
    jam = 4'(v); load_n = 1'b0;
    #1;
    expect_u(0, "R5 async load", v, (v != 9), 1'b1);
    go();
    cyc(3);
    load_n = 1'b1;
    cyc(3);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got run still active, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R12: reset state
    cyc(3);
    expect_u(0, "R12 reset", 0, 1, 1);
    expect_u(2, "R12 reset", 0, 1, 1);
    go();
    rst_n = 1'b1;
    cyc(4);

    // R6 R8 R9 R10: decade walk 7,8,9,0,1,2,1,0,9,8,7
    preset(7);
    expect_u(1, "R5 load second stage", 7, 1, 1); go();
    up_lo();
    expect_u(0, "R8 no carry below top", 7, 1, 1); go();
    up_hi();
    expect_u(0, "R1 up count", 8, 1, 1); go();
    up_pulse();
    expect_u(0, "R1 up count", 9, 1, 1); go();
    up_lo();
    expect_u(0, "R8 carry low at nine", 9, 0, 1);
    expect_u(2, "R8 binary no carry at nine", 9, 1, 1); go();
    up_hi();
    expect_u(0, "R6 wrap 9 to 0", 0, 1, 1);
    expect_u(2, "R7 binary passes nine", 10, 1, 1);
    expect_u(1, "R10 cascade up", 8, 1, 1); go();
    up_pulse(); up_pulse();
    expect_u(0, "R1 up count", 2, 1, 1);
    expect_u(2, "R1 up count binary", 12, 1, 1); go();
    dn_lo();
    expect_u(0, "R9 no borrow above zero", 2, 1, 1); go();
    dn_hi(); dn_pulse();
    expect_u(0, "R2 down count", 0, 1, 1); go();
    dn_lo();
    expect_u(0, "R9 borrow low at zero", 0, 1, 0);
    expect_u(2, "R9 binary no borrow", 10, 1, 1); go();
    dn_hi();
    expect_u(0, "R6 wrap 0 to 9", 9, 1, 1);
    expect_u(1, "R10 cascade down", 7, 1, 1);
    expect_u(2, "R2 down count binary", 9, 1, 1); go();
    dn_pulse(); dn_pulse();
    expect_u(0, "R2 down count", 7, 1, 1);
    expect_u(2, "R2 down count binary", 7, 1, 1); go();

    // R1 R2 R3: gating by the opposite strobe
    dn_lo();
    up_pulse();
    expect_u(0, "R1 up ignored with down low", 7, 1, 1); go();
    dn_hi();
    expect_u(0, "R2 down counted", 6, 1, 1); go();
    up_lo();
    dn_pulse();
    expect_u(0, "R2 down ignored with up low", 6, 1, 1); go();
    up_hi();
    expect_u(0, "R1 up counted", 7, 1, 1); go();
    inc_clk = 1'b0; dec_clk = 1'b0; cyc(P);
    inc_clk = 1'b1; dec_clk = 1'b1; cyc(P);
    expect_u(0, "R3 simultaneous edges hold", 7, 1, 1);
    expect_u(2, "R3 simultaneous edges hold", 7, 1, 1); go();
    cyc(20);
    expect_u(0, "R3 idle hold", 7, 1, 1);
    expect_u(1, "R3 second stage idle", 7, 1, 1); go();

    // R7 R11: binary wrap and decade out-of-range
    preset(15);
    up_lo();
    expect_u(2, "R8 binary carry at 15", 15, 0, 1);
    expect_u(0, "R11 no carry at 15", 15, 1, 1); go();
    up_hi();
    expect_u(2, "R7 wrap 15 to 0", 0, 1, 1);
    expect_u(0, "R11 15 wraps to 0", 0, 1, 1);
    expect_u(1, "R10 no spurious carry", 15, 1, 1); go();
    dn_lo();
    expect_u(2, "R9 binary borrow at zero", 0, 1, 0); go();
    dn_hi();
    expect_u(2, "R7 wrap 0 to 15", 15, 1, 1);
    expect_u(0, "R6 wrap 0 to 9", 9, 1, 1);
    expect_u(1, "R10 cascade down", 14, 1, 1); go();
    preset(12);
    up_pulse();
    expect_u(0, "R11 12 steps to 13", 13, 1, 1); go();
    dn_pulse();
    expect_u(0, "R11 13 steps to 12", 12, 1, 1); go();

    // R5: load blocks counting and is kept after release
    @(negedge clk);
    jam = 4'd3; load_n = 1'b0;
    cyc(2);
    up_pulse();
    expect_u(0, "R5 no count during load", 3, 1, 1);
    expect_u(2, "R5 no count during load", 3, 1, 1); go();
    load_n = 1'b1;
    cyc(3);
    expect_u(0, "R5 value kept after load", 3, 1, 1); go();

    // R4: clear overrides load and counting
    jam = 4'd5; load_n = 1'b0;
    cyc(2);
    clear = 1'b1;
    #1;
    expect_u(0, "R4 async clear over load", 0, 1, 1); go();
    up_pulse();
    expect_u(0, "R4 no count during clear", 0, 1, 1); go();
    clear = 1'b0;
    #1;
    expect_u(0, "R5 load after clear release", 5, 1, 1); go();
    cyc(2);
    load_n = 1'b1;
    cyc(3);
    expect_u(0, "R5 value kept", 5, 1, 1); go();
    clear = 1'b1;
    cyc(2);
    clear = 1'b0;
    cyc(3);
    expect_u(0, "R4 zero kept after clear", 0, 1, 1); go();

    // R12: reset mid-run
    preset(6);
    rst_n = 1'b0;
    #1;
    expect_u(0, "R12 reset mid-run", 0, 1, 1); go();

    done = 1'b1;
    summary();
    $finish;
  end

endmodule